// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates between five interrupt sources (external line 0, timer 0, external line 1, timer 1 and the serial channel) on behalf of a small CPU core. The core supplies an 8-bit mask register, a 5-bit level register and the raw per-source request flags. The controller combines these with its own record of which priority levels are being serviced. It raises a request toward the core together with the fixed vector address of the source that would be taken.

The request and the acknowledge form a valid/ready pair. `int_req` is the valid side and `int_ack` is the ready side. A grant happens only on a clock edge where both are high. The core may hold `int_ack` low for as long as it likes; nothing is lost, because the request stays derived from the live flags and `vec_addr` tracks the current winner. `int_ack` has no effect while `int_req` is low. A one-cycle `int_ret` pulse tells the controller that a service routine has finished. Stack handling and instruction execution stay inside the core.

Top module: `icu_two_level`

## Requirements
- R1: After reset `int_req` is 0, `ack_src` reads 7 (no source), and neither level is in service.
- R2: While mask bit 7 (the global gate) is 0, `int_req` stays 0 whatever the other mask bits and the request flags hold.
- R3: Mask bits 0..4 enable external 0, timer 0, external 1, timer 1 and serial respectively. A source whose bit is 0 is never requested.
- R4: `int_req` is high only in a cycle where `insn_boundary` is high.
- R5: While `int_req` is high, `vec_addr` is 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for source code 0..4 (external 0, timer 0, external 1, timer 1, serial). Otherwise `vec_addr` is 0.
- R6: A level-register bit of 1 makes its source high priority. A pending high source wins over any pending low source.
- R7: Among pending sources of the same level, the lowest source code wins.
- R8: On a grant (`int_req` and `int_ack` both high at a clock edge), the winner's level becomes in service, and from the next cycle `ack_src` holds the winner's source code.
- R9: While the high level is in service, no request is raised.
- R10: While only the low level is in service, only high-priority sources are requested.
- R11: An `int_ret` pulse clears the high in-service flag if it is set, and otherwise the low one. If a grant lands in the same cycle, the grant's level is set after that clear.
- R12: `int_ack` while `int_req` is low changes neither `ack_src` nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_mask | input | 8 | Mask register: bit 7 global gate, bits 0..4 per source |
| irq_level | input | 5 | Level register: 1 = high priority, per source code |
| src_req | input | 5 | Raw request flags, per source code |
| insn_boundary | input | 1 | Core is between instructions |
| int_ack | input | 1 | Core accepts the offered interrupt (ready) |
| int_ret | input | 1 | One-cycle return-from-service pulse |
| int_req | output | 1 | Interrupt offered to the core (valid) |
| vec_addr | output | 16 | Vector of the offered source, 0 when none |
| ack_src | output | 3 | Code of the last granted source, 7 after reset |

## Verification
The bench builds the block with its default parameters: five sources, a 16-bit vector, base 0x0003 and step 8. These values put every vector address and both priority levels within reach of short directed sequences. Directed phases cover the global gate, each mask bit, the polling order, high-over-low arbitration, nesting one level deep, and return ordering. A long random phase then mixes masks, levels, acknowledges and returns, so that grant and return land in the same cycle and acknowledges arrive without a request.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ICU_NSRC     = 5;
  localparam int ICU_ID_W     = 3;
  localparam int ICU_VEC_W    = 16;
  localparam int ICU_MASK_W   = 8;
  localparam int ICU_GATE_BIT = 7;
  localparam int ICU_VEC_BASE = 3;
  localparam int ICU_VEC_STEP = 8;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } icu_level_e;
endpackage

// File: rtl/icu_pick.sv
module icu_pick #(
  parameter int NSRC = 5,
  parameter int ID_W = 3
) (
  input  logic [NSRC-1:0] cand,
  output logic            hit,
  output logic [ID_W-1:0] id
);
  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    hit = |cand;
    id  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) id = ID_W'(i);
    end
  end
endmodule

// File: rtl/icu_inservice.sv
module icu_inservice
  import icu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  icu_level_e set_lvl,
  input  logic       ret,
  output logic [1:0] ins
);
  logic [1:0] ins_nx;

  always_comb begin
    ins_nx = ins;
    if (ret) begin
      if (ins[LVL_HI]) ins_nx[LVL_HI] = 1'b0;
      else             ins_nx[LVL_LO] = 1'b0;
    end
    if (set_en) ins_nx[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins <= '0;
    else        ins <= ins_nx;
  end
endmodule

// File: rtl/icu_two_level.sv
module icu_two_level
  import icu_pkg::*;
#(
  parameter int NSRC     = ICU_NSRC,
  parameter int ID_W     = ICU_ID_W,
  parameter int VEC_W    = ICU_VEC_W,
  parameter int MASK_W   = ICU_MASK_W,
  parameter int GATE_BIT = ICU_GATE_BIT,
  parameter int VEC_BASE = ICU_VEC_BASE,
  parameter int VEC_STEP = ICU_VEC_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] irq_mask,
  input  logic [NSRC-1:0]   irq_level,
  input  logic [NSRC-1:0]   src_req,
  input  logic              insn_boundary,
  input  logic              int_ack,
  input  logic              int_ret,
  output logic              int_req,
  output logic [VEC_W-1:0]  vec_addr,
  output logic [ID_W-1:0]   ack_src
);
  localparam logic [ID_W-1:0] NONE_ID = '1;
  localparam int NLVL = 2;

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] cand [NLVL];
  logic [NLVL-1:0] lvl_hit;
  logic [ID_W-1:0] lvl_id [NLVL];
  logic [1:0]      ins_q;
  logic            take_hi, take_lo, grant;
  logic [ID_W-1:0] win_id;

  assign live = src_req & irq_mask[NSRC-1:0] & {NSRC{irq_mask[GATE_BIT]}};

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    if (l == int'(LVL_HI)) begin : g_hi
      assign cand[l] = live & irq_level;
    end else begin : g_lo
      assign cand[l] = live & ~irq_level;
    end
    icu_pick #(.NSRC(NSRC), .ID_W(ID_W)) u_pick (
      .cand (cand[l]),
      .hit  (lvl_hit[l]),
      .id   (lvl_id[l])
    );
  end

  assign take_hi = lvl_hit[LVL_HI] && !ins_q[LVL_HI];
  assign take_lo = lvl_hit[LVL_LO] && (ins_q == 2'b00) && !take_hi;
  assign win_id  = take_hi ? lvl_id[LVL_HI] : lvl_id[LVL_LO];
  assign int_req = insn_boundary && (take_hi || take_lo);
  assign grant   = int_req && int_ack;

  always_comb begin
    vec_addr = '0;
    if (int_req) vec_addr = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_id);
  end

  icu_inservice u_ins (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (grant),
    .set_lvl (take_hi ? LVL_HI : LVL_LO),
    .ret     (int_ret),
    .ins     (ins_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ack_src <= NONE_ID;
    else if (grant) ack_src <= win_id;
  end
endmodule

// File: rtl/icu_two_level_chk.sv
module icu_two_level_chk #(
  parameter int NSRC     = 5,
  parameter int ID_W     = 3,
  parameter int VEC_W    = 16,
  parameter int MASK_W   = 8,
  parameter int GATE_BIT = 7,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MASK_W-1:0] irq_mask,
  input logic [NSRC-1:0]   irq_level,
  input logic              insn_boundary,
  input logic              int_ack,
  input logic              int_ret,
  input logic              int_req,
  input logic [VEC_W-1:0]  vec_addr,
  input logic [ID_W-1:0]   ack_src,
  input logic [1:0]        ins_q
);
  logic [VEC_W-1:0] src_of_vec;
  assign src_of_vec = (vec_addr - VEC_W'(VEC_BASE)) / VEC_W'(VEC_STEP);

  // R2
  a_r2_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask[GATE_BIT] |-> !int_req);
  // R4
  a_r4_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> insn_boundary);
  // R5
  a_r5_vec_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (vec_addr >= VEC_W'(VEC_BASE)) && (src_of_vec < VEC_W'(NSRC))
                && (((vec_addr - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STEP)) == '0));
  // R8
  a_r8_ack_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> (VEC_W'(ack_src) == $past(src_of_vec)) && (ins_q != 2'b00));
  // R9
  a_r9_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q[1] |-> !int_req);
  // R10
  a_r10_lo_only_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_q[0] && int_req) |-> (((irq_level >> src_of_vec) & NSRC'(1)) != '0));
  // R11
  a_r11_ret_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_q[1] && int_ret && !int_ack) |=> !ins_q[1] && (ins_q[0] == $past(ins_q[0])));
  // R12
  a_r12_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_req && !int_ret) |=> $stable(ack_src) && $stable(ins_q));
endmodule

bind icu_two_level icu_two_level_chk #(
  .NSRC(NSRC), .ID_W(ID_W), .VEC_W(VEC_W), .MASK_W(MASK_W),
  .GATE_BIT(GATE_BIT), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .irq_level(irq_level),
  .insn_boundary(insn_boundary), .int_ack(int_ack), .int_ret(int_ret),
  .int_req(int_req), .vec_addr(vec_addr), .ack_src(ack_src), .ins_q(ins_q)
);

// File: tb/icu_two_level_bench.sv
`timescale 1ns/1ps
module icu_two_level_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  irq_mask;
  logic [4:0]  irq_level, src_req;
  logic        insn_boundary, int_ack, int_ret;
  logic        int_req;
  logic [15:0] vec_addr;
  logic [2:0]  ack_src;

  icu_two_level u_icu_two_level (
    .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .irq_level(irq_level),
    .src_req(src_req), .insn_boundary(insn_boundary), .int_ack(int_ack),
    .int_ret(int_ret), .int_req(int_req), .vec_addr(vec_addr), .ack_src(ack_src)
  );

  int    checks = 0, fails = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference
  bit m_hi, m_lo;
  int m_id;

  function automatic void model_eval(output bit r, output int vec, output int id);
    int wh = -1, wl = -1;
    for (int i = 4; i >= 0; i--) begin
      if (irq_mask[7] && irq_mask[i] && src_req[i]) begin
        if (irq_level[i]) wh = i; else wl = i;
      end
    end
    id = -1;
    if (wh >= 0 && !m_hi) id = wh;
    else if (wl >= 0 && !m_hi && !m_lo) id = wl;
    r   = insn_boundary && (id >= 0);
    vec = r ? 3 + 8 * id : 0;
  endfunction

  always @(posedge clk) begin
    bit r; int v, id;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_id = 7;
    end else begin
      model_eval(r, v, id);
      if (int_ret) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      if (r && int_ack) begin
        if (irq_level[id]) m_hi = 1; else m_lo = 1;
        m_id = id;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always begin
    bit r; int v, id;
    @(negedge clk); #4;
    if (rst_n && !done) begin
      model_eval(r, v, id);
      check(tag, "int_req", int_req, r);
      check(tag, "vec_addr", vec_addr, v);
      check(tag, "ack_src", ack_src, m_id);
    end
  end

  task automatic drive(logic [7:0] m, logic [4:0] lv, logic [4:0] rq,
                       logic b, logic a, logic rt);
    @(negedge clk);
    irq_mask = m; irq_level = lv; src_req = rq;
    insn_boundary = b; int_ack = a; int_ret = rt;
    #4;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; irq_mask = 0; irq_level = 0; src_req = 0;
    insn_boundary = 0; int_ack = 0; int_ret = 0;
    repeat (3) @(negedge clk);
    #4;
    check("R1", "reset int_req", int_req, 0);
    check("R1", "reset ack_src", ack_src, 7);
    rst_n = 1;
    tag = "R1";
    drive(8'h00, 5'h00, 5'h1F, 1, 0, 0);
    check("R1", "masked after reset", int_req, 0);

    tag = "R2";
    drive(8'h1F, 5'h00, 5'h1F, 1, 1, 0);
    check("R2", "gate off int_req", int_req, 0);
    drive(8'h7F, 5'h1F, 5'h1F, 1, 1, 0);
    check("R2", "gate off high level", int_req, 0);

    tag = "R3";
    drive(8'h84, 5'h00, 5'h1B, 1, 0, 0);
    check("R3", "disabled sources", int_req, 0);
    drive(8'h84, 5'h00, 5'h04, 1, 0, 0);
    check("R3", "ext1 enabled vec", vec_addr, 16'h0013);

    tag = "R4";
    drive(8'h9F, 5'h00, 5'h1F, 0, 0, 0);
    check("R4", "no boundary", int_req, 0);

    tag = "R5";
    for (int s = 0; s < 5; s++) begin
      drive(8'h80 | (8'h01 << s), 5'h00, 5'h01 << s, 1, 0, 0);
      check("R5", "vector", vec_addr, 3 + 8 * s);
      drive(8'h80 | (8'h01 << s), 5'h00, 5'h01 << s, 1, 1, 0);
      drive(8'h80, 5'h00, 5'h00, 1, 0, 0);
      check("R8", "ack_src", ack_src, s);
      drive(8'h80, 5'h00, 5'h00, 1, 0, 1);
    end

    tag = "R6";
    drive(8'h9F, 5'h10, 5'h11, 1, 0, 0);
    check("R6", "high serial over low ext0", vec_addr, 16'h0023);

    tag = "R7";
    drive(8'h9F, 5'h00, 5'h1F, 1, 0, 0);
    check("R7", "ext0 first", vec_addr, 16'h0003);
    drive(8'h9E, 5'h00, 5'h1E, 1, 0, 0);
    check("R7", "timer0 next", vec_addr, 16'h000B);

    tag = "R10";
    drive(8'h9F, 5'h08, 5'h02, 1, 1, 0);      // grant timer0 at low level
    drive(8'h9F, 5'h08, 5'h07, 1, 0, 0);
    check("R10", "low blocked by low", int_req, 0);
    drive(8'h9F, 5'h08, 5'h0F, 1, 0, 0);
    check("R10", "high preempts low", vec_addr, 16'h001B);
    drive(8'h9F, 5'h08, 5'h0F, 1, 1, 0);      // grant timer1 at high level

    tag = "R9";
    drive(8'h9F, 5'h1F, 5'h1F, 1, 0, 0);
    check("R9", "high in service blocks", int_req, 0);

    tag = "R12";
    drive(8'h9F, 5'h08, 5'h0F, 0, 1, 0);
    drive(8'h9F, 5'h08, 5'h0F, 1, 0, 0);
    check("R12", "ack_src unchanged", ack_src, 3);

    tag = "R11";
    drive(8'h9F, 5'h08, 5'h0F, 0, 0, 1);      // clears high
    drive(8'h9F, 5'h08, 5'h08, 1, 0, 0);
    check("R11", "high cleared first", int_req, 1);
    drive(8'h9F, 5'h00, 5'h01, 1, 0, 0);
    check("R11", "low still held", int_req, 0);
    drive(8'h9F, 5'h00, 5'h01, 0, 0, 1);      // clears low
    drive(8'h9F, 5'h00, 5'h01, 1, 0, 0);
    check("R11", "low cleared", int_req, 1);

    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom_range(0, 3) != 0) ? 8'h80 | 8'($urandom) : 8'($urandom),
            5'($urandom), 5'($urandom), $urandom_range(0, 3) != 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule